// File: doc/BRIEF.md
# Directory Home Transaction Controller

This block is the home side of a directory protocol for a group of blocks. For each block it keeps a stable state: Uncached, Shared with a sharer bit-vector, or Modified with one owner ID. It also keeps a small data buffer for each block. An exclusive-read request keeps its transaction open in an explicit transient phase. The phase ends only when the requester has acknowledged the data, every sharer has returned its invalidation acknowledgement, or the owner has flushed the block or reported that it no longer holds it. Only then does the entry move to Modified with the requester as sole owner.

A single transaction engine serialises races. While any transaction is open, each new request gets a Nack and must be retried by its sender. Plain shared reads are served directly from Uncached or Shared entries, with the requester added to the sharer vector. All outgoing traffic (Data, Inv, Nack) leaves through one registered message port, one message per cycle.

Top module: `hnc_home_ctrl`

## Requirements
- R1: After reset every entry is Uncached with an empty sharer vector and zero data, and no message is sent until a request arrives.
- R2: A read (req_kind_i=0) to an Uncached or Shared block, with no transaction open, is answered in the next cycle by a Data message (msg_kind_o=1) to the requester carrying the block's buffered data, and the requester is added as a sharer. A read to a Modified block is answered by a Nack (msg_kind_o=3).
- R3: An exclusive read (req_kind_i=1) to an Uncached block is answered in the next cycle by Data to the requester. The transaction stays open until a completion acknowledgement (ack_kind_i=0) from the requester for that block, and closes one cycle after it.
- R4: An exclusive read to a Shared block sends Data to the requester first. It then sends one Inv (msg_kind_o=2) per cycle to each sharer other than the requester, in ascending node-ID order.
- R5: An exclusive read to a Shared block closes only after an invalidation acknowledgement (ack_kind_i=1) has arrived from every invalidated sharer and the requester's completion acknowledgement has also arrived. Acknowledgements from other nodes, or for other blocks, are ignored.
- R6: An exclusive read to a Modified block owned by another node sends an Inv to the owner and no Data from home. A flush (ack_kind_i=2) from the owner writes ack_data_i into the block buffer and closes the transaction in the same cycle.
- R7: If the owner instead reports that it no longer holds the block (ack_kind_i=3), home sends Data from its own buffer to the requester in the next cycle with no incoming request, and closes the transaction in that cycle.
- R8: While a transaction is open, any incoming request gets a Nack to its sender in the next cycle. An Inv due in that cycle is postponed by one cycle.
- R9: On close the entry becomes Modified with the requester as sole owner and the sharer vector cleared. Later reads are Nacked, and a later exclusive read from another node sends an Inv to that new owner only.
- R10: If the requester is the only sharer, an exclusive read to a Shared block sends no Inv and closes after the requester's acknowledgement.
- R11: An exclusive read from the node that already owns the Modified block is answered with Data and closes after that node's acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 1 | 0 read, 1 exclusive read |
| req_src_i | input | $clog2(NODES) | Requesting node |
| req_addr_i | input | $clog2(BLOCKS) | Block index |
| ack_valid_i | input | 1 | Acknowledgement present this cycle |
| ack_kind_i | input | 2 | 0 completion, 1 inv ack, 2 flush, 3 owner lost block |
| ack_src_i | input | $clog2(NODES) | Sending node |
| ack_addr_i | input | $clog2(BLOCKS) | Block index |
| ack_data_i | input | DATA_W | Flushed block data |
| msg_valid_o | output | 1 | Message valid |
| msg_kind_o | output | 2 | 1 Data, 2 Inv, 3 Nack |
| msg_dst_o | output | $clog2(NODES) | Destination node |
| msg_addr_o | output | $clog2(BLOCKS) | Block index |
| msg_data_o | output | DATA_W | Data payload (Data messages) |

## Verification
A corrupted sharer vector shows up one or more cycles after an exclusive read: an Inv goes to the wrong node, or an expected Inv never comes. A corrupted owner field shows as an Inv to the wrong destination in the very next cycle after an exclusive read to that block. An early close shows as a served request where a Nack was due, in the first cycle after the missing acknowledgement. A late close or a missed state update shows as a Nack where service was due, or as Data to a read of a block that should be Modified. A lost flush shows as stale payload on the next Data message for that block.

// File: rtl/hnc_pkg.sv
package hnc_pkg;
  typedef enum logic [1:0] {BLK_U = 2'd0, BLK_S = 2'd1, BLK_M = 2'd2} blk_st_e;
  typedef enum logic [1:0] {MSG_NONE = 2'd0, MSG_DATA = 2'd1, MSG_INV = 2'd2, MSG_NACK = 2'd3} msg_kind_e;
  typedef enum logic [1:0] {AK_DONE = 2'd0, AK_INV = 2'd1, AK_FLUSH = 2'd2, AK_GONE = 2'd3} ack_kind_e;
  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_COLLECT = 2'd1, TX_OWNER = 2'd2, TX_SUPPLY = 2'd3} tx_st_e;
endpackage

// File: rtl/hnc_dir_store.sv
module hnc_dir_store
  import hnc_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int IDW = $clog2(NODES),
  localparam int AW  = $clog2(BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  output blk_st_e           rd_st_o,
  output logic [NODES-1:0]  rd_sh_o,
  output logic [IDW-1:0]    rd_own_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              upd_en_i,
  input  blk_st_e           upd_st_i,
  input  logic [NODES-1:0]  upd_sh_i,
  input  logic [IDW-1:0]    upd_own_i,
  input  logic              mem_we_i,
  input  logic [DATA_W-1:0] mem_wdata_i
);
  blk_st_e           st_q  [BLOCKS];
  logic [NODES-1:0]  sh_q  [BLOCKS];
  logic [IDW-1:0]    own_q [BLOCKS];
  logic [DATA_W-1:0] mem_q [BLOCKS];

  assign rd_st_o   = st_q[addr_i];
  assign rd_sh_o   = sh_q[addr_i];
  assign rd_own_o  = own_q[addr_i];
  assign rd_data_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]  <= BLK_U;
        sh_q[b]  <= '0;
        own_q[b] <= '0;
        mem_q[b] <= '0;
      end
    end else begin
      if (upd_en_i) begin
        st_q[addr_i]  <= upd_st_i;
        sh_q[addr_i]  <= upd_sh_i;
        own_q[addr_i] <= upd_own_i;
      end
      if (mem_we_i) mem_q[addr_i] <= mem_wdata_i;
    end
  end

  // Modified entries never carry sharers
  p_m_no_sharers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st_o == BLK_M) |-> (rd_sh_o == '0));
  // Uncached entries never carry sharers
  p_u_no_sharers_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st_o == BLK_U) |-> (rd_sh_o == '0));
endmodule

// File: rtl/hnc_inv_tracker.sv
module hnc_inv_tracker #(
  parameter int NODES = 4,
  localparam int IDW = $clog2(NODES),
  localparam int CW  = $clog2(NODES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NODES-1:0] load_mask_i,
  input  logic             issue_en_i,
  input  logic             ack_v_i,
  input  logic [IDW-1:0]   ack_src_i,
  output logic             issue_v_o,
  output logic [IDW-1:0]   issue_dst_o,
  output logic [CW-1:0]    cnt_o,
  output logic             pend_empty_o
);
  logic [NODES-1:0] pend_q, wait_q;
  logic [CW-1:0]    cnt_q;
  logic             ack_hit;

  always_comb begin
    issue_v_o   = 1'b0;
    issue_dst_o = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        issue_v_o   = 1'b1;
        issue_dst_o = IDW'(i);
      end
    end
  end

  assign ack_hit      = ack_v_i && wait_q[ack_src_i];
  assign cnt_o        = cnt_q;
  assign pend_empty_o = (pend_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= load_mask_i;
      wait_q <= load_mask_i;
      cnt_q  <= CW'($countones(load_mask_i));
    end else begin
      if (issue_en_i && issue_v_o) pend_q[issue_dst_o] <= 1'b0;
      if (ack_hit) begin
        wait_q[ack_src_i] <= 1'b0;
        cnt_q             <= cnt_q - 1'b1;
      end
    end
  end

  p_cnt_matches_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CW'($countones(wait_q)));
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit |-> (cnt_q != '0));
  p_issue_one_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en_i && issue_v_o && !load_i) |=> !pend_q[$past(issue_dst_o)]);
endmodule

// File: rtl/hnc_txn_fsm.sv
module hnc_txn_fsm
  import hnc_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int IDW = $clog2(NODES),
  localparam int AW  = $clog2(BLOCKS),
  localparam int CW  = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  input  logic [IDW-1:0]    req_src_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              ack_valid_i,
  input  logic [1:0]        ack_kind_i,
  input  logic [IDW-1:0]    ack_src_i,
  input  logic [AW-1:0]     ack_addr_i,
  input  logic [DATA_W-1:0] ack_data_i,
  input  blk_st_e           ent_st_i,
  input  logic [NODES-1:0]  ent_sh_i,
  input  logic [IDW-1:0]    ent_own_i,
  input  logic [DATA_W-1:0] ent_data_i,
  output logic [AW-1:0]     dir_addr_o,
  output logic              upd_en_o,
  output blk_st_e           upd_st_o,
  output logic [NODES-1:0]  upd_sh_o,
  output logic [IDW-1:0]    upd_own_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              trk_load_o,
  output logic [NODES-1:0]  trk_mask_o,
  output logic              trk_issue_en_o,
  output logic              trk_ack_v_o,
  input  logic              trk_issue_v_i,
  input  logic [IDW-1:0]    trk_dst_i,
  input  logic [CW-1:0]     trk_cnt_i,
  input  logic              trk_empty_i,
  output logic              busy_o,
  output logic              msg_valid_o,
  output logic [1:0]        msg_kind_o,
  output logic [IDW-1:0]    msg_dst_o,
  output logic [AW-1:0]     msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  tx_st_e            st_q, st_d;
  logic [AW-1:0]     act_addr_q, act_addr_d;
  logic [IDW-1:0]    act_req_q, act_req_d, act_own_q, act_own_d;
  logic              got_q, got_d;
  logic              mv_d;
  msg_kind_e         mk_d;
  logic [IDW-1:0]    mdst_d;
  logic [AW-1:0]     maddr_d;
  logic [DATA_W-1:0] mdata_d;
  logic [NODES-1:0]  req_bit;
  logic              ack_here;

  assign req_bit    = NODES'(1) << req_src_i;
  assign ack_here   = ack_valid_i && (ack_addr_i == act_addr_q);
  assign busy_o     = (st_q != TX_IDLE);
  assign dir_addr_o = busy_o ? act_addr_q : req_addr_i;

  always_comb begin
    st_d           = st_q;
    act_addr_d     = act_addr_q;
    act_req_d      = act_req_q;
    act_own_d      = act_own_q;
    got_d          = got_q;
    mv_d           = 1'b0;
    mk_d           = MSG_NONE;
    mdst_d         = '0;
    maddr_d        = dir_addr_o;
    mdata_d        = '0;
    upd_en_o       = 1'b0;
    upd_st_o       = BLK_M;
    upd_sh_o       = '0;
    upd_own_o      = act_req_q;
    mem_we_o       = 1'b0;
    mem_wdata_o    = ack_data_i;
    trk_load_o     = 1'b0;
    trk_mask_o     = ent_sh_i & ~req_bit;
    trk_issue_en_o = 1'b0;
    trk_ack_v_o    = 1'b0;

    // serialise: every request seen while a transaction is open is refused
    if (req_valid_i && busy_o) begin
      mv_d    = 1'b1;
      mk_d    = MSG_NACK;
      mdst_d  = req_src_i;
      maddr_d = req_addr_i;
    end

    unique case (st_q)
      TX_IDLE: begin
        if (req_valid_i) begin
          act_addr_d = req_addr_i;
          act_req_d  = req_src_i;
          got_d      = 1'b0;
          mv_d       = 1'b1;
          mdst_d     = req_src_i;
          if (!req_kind_i) begin
            if (ent_st_i == BLK_M) begin
              mk_d = MSG_NACK;
            end else begin
              mk_d      = MSG_DATA;
              mdata_d   = ent_data_i;
              upd_en_o  = 1'b1;
              upd_st_o  = BLK_S;
              upd_sh_o  = ent_sh_i | req_bit;
              upd_own_o = ent_own_i;
            end
          end else if (ent_st_i == BLK_M && ent_own_i != req_src_i) begin
            mk_d      = MSG_INV;
            mdst_d    = ent_own_i;
            act_own_d = ent_own_i;
            st_d      = TX_OWNER;
          end else begin
            mk_d       = MSG_DATA;
            mdata_d    = ent_data_i;
            trk_load_o = 1'b1;
            st_d       = TX_COLLECT;
          end
        end
      end
      TX_COLLECT: begin
        trk_ack_v_o = ack_here && (ack_kind_i == AK_INV);
        if (ack_here && ack_kind_i == AK_DONE && ack_src_i == act_req_q) got_d = 1'b1;
        if (!req_valid_i) begin
          trk_issue_en_o = 1'b1;
          if (trk_issue_v_i) begin
            mv_d   = 1'b1;
            mk_d   = MSG_INV;
            mdst_d = trk_dst_i;
          end
        end
        if (got_q && trk_cnt_i == '0 && trk_empty_i) begin
          upd_en_o = 1'b1;
          st_d     = TX_IDLE;
        end
      end
      TX_OWNER: begin
        if (ack_here && ack_src_i == act_own_q) begin
          if (ack_kind_i == AK_FLUSH) begin
            mem_we_o = 1'b1;
            upd_en_o = 1'b1;
            st_d     = TX_IDLE;
          end else if (ack_kind_i == AK_GONE) begin
            st_d = TX_SUPPLY;
          end
        end
      end
      TX_SUPPLY: begin
        if (!req_valid_i) begin
          mv_d     = 1'b1;
          mk_d     = MSG_DATA;
          mdst_d   = act_req_q;
          mdata_d  = ent_data_i;
          upd_en_o = 1'b1;
          st_d     = TX_IDLE;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= TX_IDLE;
      act_addr_q  <= '0;
      act_req_q   <= '0;
      act_own_q   <= '0;
      got_q       <= 1'b0;
      msg_valid_o <= 1'b0;
      msg_kind_o  <= MSG_NONE;
      msg_dst_o   <= '0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else begin
      st_q        <= st_d;
      act_addr_q  <= act_addr_d;
      act_req_q   <= act_req_d;
      act_own_q   <= act_own_d;
      got_q       <= got_d;
      msg_valid_o <= mv_d;
      msg_kind_o  <= mk_d;
      msg_dst_o   <= mdst_d;
      msg_addr_o  <= maddr_d;
      msg_data_o  <= mdata_d;
    end
  end

  p_busy_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && st_q != TX_IDLE) |=> (msg_valid_o && msg_kind_o == MSG_NACK));
  p_read_served_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && req_valid_i && !req_kind_i && ent_st_i != BLK_M)
      |=> (msg_valid_o && msg_kind_o == MSG_DATA));
  p_hold_for_acks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_COLLECT && trk_cnt_i != '0) |=> (st_q != TX_IDLE));
  p_owner_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && req_valid_i && req_kind_i && ent_st_i == BLK_M && ent_own_i != req_src_i)
      |=> (msg_valid_o && msg_kind_o == MSG_INV && msg_dst_o == $past(ent_own_i)));
  p_supply_closes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_SUPPLY && !req_valid_i) |=> (msg_kind_o == MSG_DATA && st_q == TX_IDLE));
endmodule

// File: rtl/hnc_home_ctrl.sv
module hnc_home_ctrl
  import hnc_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int IDW = $clog2(NODES),
  localparam int AW  = $clog2(BLOCKS),
  localparam int CW  = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  input  logic [IDW-1:0]    req_src_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              ack_valid_i,
  input  logic [1:0]        ack_kind_i,
  input  logic [IDW-1:0]    ack_src_i,
  input  logic [AW-1:0]     ack_addr_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_kind_o,
  output logic [IDW-1:0]    msg_dst_o,
  output logic [AW-1:0]     msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  logic [AW-1:0]     dir_addr;
  blk_st_e           ent_st, upd_st;
  logic [NODES-1:0]  ent_sh, upd_sh, trk_mask;
  logic [IDW-1:0]    ent_own, upd_own, trk_dst;
  logic [DATA_W-1:0] ent_data, mem_wdata;
  logic              upd_en, mem_we, trk_load, trk_issue_en, trk_ack_v, trk_issue_v, trk_empty;
  logic [CW-1:0]     trk_cnt;
  logic              busy;

  hnc_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .addr_i     (dir_addr),
    .rd_st_o    (ent_st),
    .rd_sh_o    (ent_sh),
    .rd_own_o   (ent_own),
    .rd_data_o  (ent_data),
    .upd_en_i   (upd_en),
    .upd_st_i   (upd_st),
    .upd_sh_i   (upd_sh),
    .upd_own_i  (upd_own),
    .mem_we_i   (mem_we),
    .mem_wdata_i(mem_wdata)
  );

  hnc_inv_tracker #(.NODES(NODES)) u_trk (
    .clk_i, .rst_ni,
    .load_i      (trk_load),
    .load_mask_i (trk_mask),
    .issue_en_i  (trk_issue_en),
    .ack_v_i     (trk_ack_v),
    .ack_src_i   (ack_src_i),
    .issue_v_o   (trk_issue_v),
    .issue_dst_o (trk_dst),
    .cnt_o       (trk_cnt),
    .pend_empty_o(trk_empty)
  );

  hnc_txn_fsm #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_kind_i, .req_src_i, .req_addr_i,
    .ack_valid_i, .ack_kind_i, .ack_src_i, .ack_addr_i, .ack_data_i,
    .ent_st_i      (ent_st),
    .ent_sh_i      (ent_sh),
    .ent_own_i     (ent_own),
    .ent_data_i    (ent_data),
    .dir_addr_o    (dir_addr),
    .upd_en_o      (upd_en),
    .upd_st_o      (upd_st),
    .upd_sh_o      (upd_sh),
    .upd_own_o     (upd_own),
    .mem_we_o      (mem_we),
    .mem_wdata_o   (mem_wdata),
    .trk_load_o    (trk_load),
    .trk_mask_o    (trk_mask),
    .trk_issue_en_o(trk_issue_en),
    .trk_ack_v_o   (trk_ack_v),
    .trk_issue_v_i (trk_issue_v),
    .trk_dst_i     (trk_dst),
    .trk_cnt_i     (trk_cnt),
    .trk_empty_i   (trk_empty),
    .busy_o        (busy),
    .msg_valid_o, .msg_kind_o, .msg_dst_o, .msg_addr_o, .msg_data_o
  );

  // a message goes out only in reply to a request or during an open transaction
  p_msg_has_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !busy) |=> !msg_valid_o);
endmodule

// File: tb/hnc_home_ctrl_bench.sv
module hnc_home_ctrl_bench;
  localparam int N  = 4;
  localparam int B  = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_kind = 1'b0;
  logic [1:0]    req_src = '0;
  logic [2:0]    req_addr = '0;
  logic          ack_valid = 1'b0;
  logic [1:0]    ack_kind = '0, ack_src = '0;
  logic [2:0]    ack_addr = '0;
  logic [DW-1:0] ack_data = '0;
  logic          msg_valid;
  logic [1:0]    msg_kind, msg_dst;
  logic [2:0]    msg_addr;
  logic [DW-1:0] msg_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  int            m_st [B];
  logic [N-1:0]  m_sh [B];
  int            m_own[B];
  logic [DW-1:0] m_mem[B];

  always #2 clk = ~clk;

  hnc_home_ctrl #(.NODES(N), .BLOCKS(B), .DATA_W(DW)) u_hnc_home_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_src_i(req_src), .req_addr_i(req_addr),
    .ack_valid_i(ack_valid), .ack_kind_i(ack_kind), .ack_src_i(ack_src), .ack_addr_i(ack_addr),
    .ack_data_i(ack_data),
    .msg_valid_o(msg_valid), .msg_kind_o(msg_kind), .msg_dst_o(msg_dst), .msg_addr_o(msg_addr),
    .msg_data_o(msg_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_msg(string r, int kind, int dst, int addr, logic [DW-1:0] data);
    bit ok;
    n_tests++;
    ok = msg_valid && (int'(msg_kind) == kind) && (int'(msg_dst) == dst) && (int'(msg_addr) == addr);
    if (kind == 1) ok = ok && (msg_data == data);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got v=%0d k=%0d dst=%0d addr=%0d data=%h exp v=1 k=%0d dst=%0d addr=%0d data=%h",
               r, msg_valid, msg_kind, msg_dst, msg_addr, msg_data, kind, dst, addr, data);
    end
  endtask

  task automatic chk_quiet(string r);
    n_tests++;
    if (msg_valid) begin
      n_fail++;
      $display("FAIL %s: got v=1 k=%0d dst=%0d exp v=0", r, msg_kind, msg_dst);
    end
  endtask

  task automatic send_req(bit kind, int src, int addr);
    req_valid = 1'b1; req_kind = kind; req_src = 2'(src); req_addr = 3'(addr);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic send_ack(int kind, int src, int addr, logic [DW-1:0] d);
    ack_valid = 1'b1; ack_kind = 2'(kind); ack_src = 2'(src); ack_addr = 3'(addr); ack_data = d;
    tick();
    ack_valid = 1'b0;
  endtask

  function automatic int lowest(logic [N-1:0] m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  // R2 read against model
  task automatic m_read(int src, int a, string tag);
    send_req(1'b0, src, a);
    if (m_st[a] == 2) chk_msg({tag, " R2 read of modified nacked"}, 3, src, a, '0);
    else begin
      chk_msg({tag, " R2 read data"}, 1, src, a, m_mem[a]);
      m_st[a] = 1;
      m_sh[a][src] = 1'b1;
    end
  endtask

  task automatic m_readx(int src, int a, bit use_flush, bit inject);
    int own;
    logic [N-1:0] rem, invd;
    logic [DW-1:0] d;
    own = m_own[a];
    send_req(1'b1, src, a);
    if (m_st[a] == 2 && own != src) begin
      chk_msg("R6 R9 inv to current owner", 2, own, a, '0);
      if (inject) begin
        send_req(1'b0, (src + 1) % N, (a + 3) % B);
        chk_msg("R8 nack while owner pending", 3, (src + 1) % N, (a + 3) % B, '0);
      end
      if (use_flush) begin
        d = DW'($urandom);
        send_ack(2, own, a, d);
        chk_quiet("R6 no home data on flush");
        m_mem[a] = d;
      end else begin
        send_ack(3, own, a, '0);
        chk_quiet("R7 no data in gone cycle");
        tick();
        chk_msg("R7 home supplies buffered data", 1, src, a, m_mem[a]);
      end
    end else begin
      if (m_st[a] == 2) chk_msg("R11 owner re-request data", 1, src, a, m_mem[a]);
      else chk_msg("R3 exclusive read data", 1, src, a, m_mem[a]);
      invd = m_sh[a] & ~(N'(1) << src);
      rem  = invd;
      while (rem != '0) begin
        if (inject) begin
          send_req(1'b1, (src + 2) % N, a);
          chk_msg("R8 nack postpones inv", 3, (src + 2) % N, a, '0);
          inject = 1'b0;
        end else begin
          tick();
          chk_msg("R4 inv ascending order", 2, lowest(rem), a, '0);
          rem[lowest(rem)] = 1'b0;
        end
      end
      tick();
      chk_quiet("R4 R10 no further inv");
      if ($urandom % 2 == 0) begin
        send_ack(0, src, a, '0);
        if (invd != '0) begin
          send_req(1'b0, (src + 1) % N, (a + 1) % B);
          chk_msg("R5 open until all inv acks", 3, (src + 1) % N, (a + 1) % B, '0);
        end
        for (int i = 0; i < N; i++) if (invd[i]) send_ack(1, i, a, '0);
      end else begin
        for (int i = 0; i < N; i++) if (invd[i]) send_ack(1, i, a, '0);
        send_req(1'b0, (src + 1) % N, (a + 1) % B);
        chk_msg("R5 R3 open until requester ack", 3, (src + 1) % N, (a + 1) % B, '0);
        send_ack(0, src, a, '0);
      end
      tick();
    end
    m_st[a] = 2;
    m_own[a] = src;
    m_sh[a] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < B; b++) begin
      m_st[b] = 0; m_sh[b] = '0; m_own[b] = 0; m_mem[b] = '0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk_quiet("R1 quiet after reset");

    // R1: block starts uncached with zero data
    send_req(1'b0, 2, 3);
    chk_msg("R1 reset entry uncached zero", 1, 2, 3, '0);
    m_st[3] = 1; m_sh[3][2] = 1'b1;

    // R3 with stray acks (R5) and nack while open (R8)
    send_req(1'b1, 1, 5);
    chk_msg("R3 data to requester", 1, 1, 5, '0);
    tick();
    chk_quiet("R3 no inv for uncached");
    send_req(1'b0, 0, 5);
    chk_msg("R8 nack same block", 3, 0, 5, '0);
    send_ack(0, 2, 5, '0);
    send_ack(0, 1, 4, '0);
    send_ack(1, 3, 5, '0);
    tick();
    send_req(1'b0, 0, 6);
    chk_msg("R5 stray acks ignored", 3, 0, 6, '0);
    send_ack(0, 1, 5, '0);
    tick();
    m_st[5] = 2; m_own[5] = 1;
    m_read(0, 5, "R9");
    m_readx(3, 5, 1'b1, 1'b0);
    m_readx(0, 5, 1'b0, 1'b1);

    // R4 shared with three sharers
    m_read(0, 2, "R4 setup");
    m_read(1, 2, "R4 setup");
    m_read(3, 2, "R4 setup");
    m_readx(1, 2, 1'b0, 1'b1);
    send_req(1'b1, 0, 2);
    chk_msg("R9 inv only new owner", 2, 1, 2, '0);
    send_ack(2, 1, 2, 16'h5a5a);
    m_mem[2] = 16'h5a5a; m_own[2] = 0;
    m_readx(2, 2, 1'b0, 1'b0);

    // R10 requester sole sharer; then R11 owner again
    m_read(2, 6, "R10 setup");
    m_readx(2, 6, 1'b0, 1'b0);
    m_readx(2, 6, 1'b0, 1'b0);

    for (int it = 0; it < 400; it++) begin
      int src, a;
      src = int'($urandom % N);
      a   = int'($urandom % B);
      if ($urandom % 3 == 0) m_read(src, a, "rand");
      else m_readx(src, a, bit'($urandom % 2), ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule